// File: doc/BRIEF.md
# Clock-Stop Serial Master

This block is the master side of an SPI-style serial link whose clock rests high. A start strobe sent while the block is idle does three things. It captures a parallel transmit word and a divider setting. It pulls the active-low slave select down and enables the data output. It then clocks the word out on the serial line, most significant bit first, while it collects the same number of bits from the serial input. When the last bit has been sent, select returns high and the output enable drops, so the data line can float. One system cycle later a done strobe presents the received word in parallel.

The bit period is (1 + divider) system clock cycles. The low phase of the serial clock depends on the parity of the divider. For an odd divider it is exactly half the period. For an even divider it is divider/2 cycles, and the high phase takes the rest of the period. A zero divider is run as the fastest legal bit time: one cycle low and one cycle high. Output data changes only on falling serial clock edges. Input data is taken on rising edges. Before the first falling edge, select is low for exactly one low-phase width. No extra half bit is added.

Top module: `spi_cs_master`

## Requirements
- R1: After reset and between transfers, `sclk` is 1, `ss_n` is 1, `mosi_oe` is 0 and `done` is 0.
- R2: `start` is accepted only while no transfer is in progress. A `start` pulse during a transfer changes neither the word sent, the word received, nor the timing of that transfer.
- R3: In the cycle after an accepted `start`, `ss_n` is 0 and `mosi_oe` is 1. `sclk` then stays high for exactly L cycles before its first falling edge, and each transfer has exactly WORD_W falling edges.
- R4: Every low phase of `sclk` lasts L cycles. L is 1 when the divider is 0, (divider+1)/2 when the divider is odd, and divider/2 when the divider is even and nonzero.
- R5: Every high phase between two low phases lasts H cycles. H is 1 when the divider is 0, and (1 + divider) − L otherwise. `ss_n` is low for exactly L + WORD_W·(L + H) cycles per transfer.
- R6: `mosi` carries `tx_word` most significant bit first. The first bit is present from the cycle `ss_n` falls. Inside a transfer, `mosi` changes only in a cycle where `sclk` falls.
- R7: `miso` is sampled at each rising edge of `sclk`. The first sample becomes bit WORD_W−1 of `rx_word`.
- R8: After the last rising edge, `sclk` stays high for H cycles. Then `ss_n` returns to 1 and `mosi_oe` returns to 0 in the same cycle. `mosi_oe` equals the inverse of `ss_n` at all times.
- R9: `done` is 1 for exactly one cycle, the cycle after `ss_n` rises. `rx_word` takes the received value in that cycle and does not change at any other time.
- R10: `div` is sampled only when `start` is accepted. Changing it during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request strobe |
| tx_word | input | WORD_W | Word to transmit |
| div | input | DIV_W | Bit-period divider; period is 1+div cycles |
| rx_word | output | WORD_W | Last received word |
| done | output | 1 | One-cycle strobe at transfer end |
| sclk | output | 1 | Serial clock, resting high |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi`; 0 means high impedance |
| miso | input | 1 | Serial data in |

## Verification
A new request can arrive in the same cycle that the engine is stepping through a bit: shifting the transmit register at a falling edge, or sampling `miso` at a rising edge. The bench provokes this collision by pulsing `start` in the middle of a transfer, with an inverted transmit word and a larger divider at the same moment. A bench slave that changes `miso` on falling edges supplies the input data. The transfer is then judged against the original word and the original divider: the measured low and high widths, the select-low cycle count, the bits collected at rising edges and the received word must all match the values computed for the first request.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_LOW   = 3'd2,
      ST_HIGH  = 3'd3,
      ST_FIN   = 3'd4
   } cs_state_e;
endpackage

// File: rtl/spi_cs_phase.sv
// Converts a divider setting into low/high phase widths in system cycles.
module spi_cs_phase #(
   parameter int DIV_W = 4,
   localparam int CNT_W = DIV_W + 1
) (
   input  logic [DIV_W-1:0] div_val,
   output logic [CNT_W-1:0] low_len,
   output logic [CNT_W-1:0] high_len
);
   logic [CNT_W-1:0] period;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_cs_phase: DIV_W must be at least 1");
      end
   endgenerate

   always_comb begin
      period = {1'b0, div_val} + CNT_W'(1);
      if (div_val == '0) begin
         low_len  = CNT_W'(1);
         high_len = CNT_W'(1);
      end else if (div_val[0]) begin
         low_len  = period >> 1;
         high_len = period - low_len;
      end else begin
         low_len  = {1'b0, div_val} >> 1;
         high_len = period - low_len;
      end
   end
endmodule

// File: rtl/spi_cs_shift.sv
// Transmit and receive shift registers, both most significant bit first.
module spi_cs_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] tx_in,
   input  logic              shift_out,
   input  logic              capture,
   input  logic              miso,
   output logic              mosi_bit,
   output logic [WORD_W-1:0] rx_bits
);
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spi_cs_shift: WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
      end else if (load) begin
         tx_sh <= tx_in;
      end else if (shift_out) begin
         tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh <= '0;
      end else if (capture) begin
         rx_sh <= {rx_sh[WORD_W-2:0], miso};
      end
   end

   assign mosi_bit = tx_sh[WORD_W-1];
   assign rx_bits  = rx_sh;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
   import spi_cs_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 4,
   localparam int CNT_W = DIV_W + 1,
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [DIV_W-1:0]  div,
   output logic [WORD_W-1:0] rx_word,
   output logic              done,
   output logic              sclk,
   output logic              ss_n,
   output logic              mosi,
   output logic              mosi_oe,
   input  logic              miso
);
   cs_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [DIV_W-1:0]  div_q;
   logic [DIV_W-1:0]  tim_div;
   logic [CNT_W-1:0]  low_len, high_len;
   logic              sclk_q, ss_q, oe_q, done_q;
   logic [WORD_W-1:0] rx_q;
   logic              load, shift_out, capture;
   logic              mosi_bit;
   logic [WORD_W-1:0] rx_bits;
   logic              accept, last_bit, cnt_end;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("spi_cs_master: WORD_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_cs_master: DIV_W must be at least 1");
      end
   endgenerate

   assign tim_div   = (state == ST_IDLE) ? div : div_q;
   assign accept    = (state == ST_IDLE) && start;
   assign cnt_end   = (cnt == '0);
   assign last_bit  = (bitn == BIT_W'(WORD_W - 1));
   assign load      = accept;
   assign shift_out = (state == ST_HIGH) && cnt_end && !last_bit;
   assign capture   = (state == ST_LOW) && cnt_end;

   spi_cs_phase #(.DIV_W(DIV_W)) u_phase (
      .div_val  (tim_div),
      .low_len  (low_len),
      .high_len (high_len)
   );

   spi_cs_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .tx_in     (tx_word),
      .shift_out (shift_out),
      .capture   (capture),
      .miso      (miso),
      .mosi_bit  (mosi_bit),
      .rx_bits   (rx_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         bitn   <= '0;
         div_q  <= '0;
         sclk_q <= 1'b1;
         ss_q   <= 1'b1;
         oe_q   <= 1'b0;
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  div_q <= div;
                  ss_q  <= 1'b0;
                  oe_q  <= 1'b1;
                  bitn  <= '0;
                  cnt   <= low_len - CNT_W'(1);
                  state <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt_end) begin
                  sclk_q <= 1'b0;
                  cnt    <= low_len - CNT_W'(1);
                  state  <= ST_LOW;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_LOW: begin
               if (cnt_end) begin
                  sclk_q <= 1'b1;
                  cnt    <= high_len - CNT_W'(1);
                  state  <= ST_HIGH;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_HIGH: begin
               if (cnt_end) begin
                  if (last_bit) begin
                     ss_q  <= 1'b1;
                     oe_q  <= 1'b0;
                     state <= ST_FIN;
                  end else begin
                     sclk_q <= 1'b0;
                     bitn   <= bitn + BIT_W'(1);
                     cnt    <= low_len - CNT_W'(1);
                     state  <= ST_LOW;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_FIN: begin
               done_q <= 1'b1;
               rx_q   <= rx_bits;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sclk    = sclk_q;
   assign ss_n    = ss_q;
   assign mosi_oe = oe_q;
   assign mosi    = oe_q ? mosi_bit : 1'b0;
   assign done    = done_q;
   assign rx_word = rx_q;

   AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n |-> sclk);                                                   // R1
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> $stable(div_q));                  // R2
   AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ss_n && !$past(ss_n) && mosi != $past(mosi)) |-> $fell(sclk));  // R6
   AST_OE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      mosi_oe == !ss_n);                                                // R8
   AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n) |=> done);                                            // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R9
   AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rx_word));                                      // R9
endmodule

// File: tb/spi_cs_master_bench.sv
module spi_cs_master_bench;
   localparam int WW = 8;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [WW-1:0] tx_word = '0;
   logic [DW-1:0] div = '0;
   logic [WW-1:0] rx_word;
   logic          done, sclk, ss_n, mosi, mosi_oe;
   logic          miso;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [WW-1:0] slv_word = '0;
   int            sidx = 0;
   bit            sfirst = 1'b1;

   always #5 clk = ~clk;

   spi_cs_master #(.WORD_W(WW), .DIV_W(DW)) u_spi_cs_master (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .div(div),
      .rx_word(rx_word), .done(done), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
      .mosi_oe(mosi_oe), .miso(miso)
   );

   // Slave model: first bit ready at select fall, next bit on each later falling edge.
   always @(negedge ss_n) begin
      sidx   = 0;
      sfirst = 1'b1;
   end
   always @(negedge sclk) begin
      if (!ss_n) begin
         if (sfirst) sfirst = 1'b0;
         else sidx = sidx + 1;
      end
   end
   assign miso = (sidx < WW) ? slv_word[WW-1-sidx] : 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_low(input int d);
      if (d == 0) return 1;
      if (d % 2 == 1) return (d + 1) / 2;
      return d / 2;
   endfunction

   function automatic int exp_high(input int d);
      if (d == 0) return 1;
      return (d + 1) - exp_low(d);
   endfunction

   task automatic xfer(input logic [WW-1:0] tx, input logic [WW-1:0] sw,
                       input int d, input bit poke);
      int lo, hi, run, setup, nfall, ss_low, bad_low, bad_high, bad_oe, guard;
      logic cur;
      logic [WW-1:0] got;
      lo = exp_low(d); hi = exp_high(d);
      run = 0; setup = -1; nfall = 0; ss_low = 0;
      bad_low = 0; bad_high = 0; bad_oe = 0; guard = 0; got = '0;
      slv_word = sw;
      tx_word  = tx;
      div      = DW'(d);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(ss_n == 1'b0 && mosi_oe == 1'b1, "R3 select/enable after start",
          {ss_n, mosi_oe}, 1);
      chk(mosi == tx[WW-1], "R6 first bit at select fall", mosi, tx[WW-1]);
      ss_low = 1; cur = sclk; run = 1;
      while (guard < 2000) begin
         guard++;
         @(negedge clk);
         if (poke && ss_low == 5) begin
            start   = 1'b1;
            tx_word = ~tx;
            div     = DW'(d + 3);
         end else begin
            start = 1'b0;
         end
         if (ss_n) break;
         ss_low++;
         if (mosi_oe !== 1'b1) bad_oe++;
         if (sclk == cur) begin
            run++;
         end else begin
            if (cur == 1'b1) begin
               if (nfall == 0) setup = run;
               else if (run != hi) bad_high++;
               nfall++;
            end else begin
               if (run != lo) bad_low++;
               got = {got[WW-2:0], mosi};
            end
            cur = sclk;
            run = 1;
         end
      end
      start = 1'b0;
      chk(guard < 2000, "R8 select released", guard, 0);
      chk(setup == lo, "R3 lead-in high width", setup, lo);
      chk(nfall == WW, "R3 falling edge count", nfall, WW);
      chk(bad_low == 0, "R4 low phase width", bad_low, 0);
      chk(bad_high == 0, "R5 high phase width", bad_high, 0);
      chk(ss_low == lo + WW * (lo + hi), "R5 select low cycles", ss_low, lo + WW * (lo + hi));
      chk(cur == 1'b1 && run == hi, "R8 final high hold", run, hi);
      chk(bad_oe == 0 && mosi_oe == 1'b0, "R8 output enable", bad_oe, 0);
      chk(got == tx, "R6 bits on mosi (R2 R10)", got, tx);
      chk(done == 1'b0, "R9 no done with select release", done, 0);
      @(negedge clk);
      chk(done == 1'b1, "R9 done after release", done, 1);
      chk(rx_word == sw, "R7 received word", rx_word, sw);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", done, 0);
      chk(rx_word == sw, "R9 rx word held", rx_word, sw);
      chk(sclk && ss_n && !mosi_oe, "R1 idle pins", {sclk, ss_n, mosi_oe}, 6);
      tx_word = '0;
      div     = '0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk == 1'b1 && ss_n == 1'b1, "R1 reset pins", {sclk, ss_n}, 3);
      chk(mosi_oe == 1'b0 && done == 1'b0, "R1 reset strobes", {mosi_oe, done}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sclk && ss_n && !mosi_oe && !done, "R1 idle after reset", {sclk, ss_n}, 3);
      for (int d = 0; d < 16; d++) begin
         xfer(8'hA5 ^ 8'(d * 17), 8'h3C ^ 8'(d * 5), d, 1'b0);
         xfer(8'h81, 8'h7E, d, 1'b0);
      end
      xfer(8'hFF, 8'h00, 0, 1'b0);
      xfer(8'h00, 8'hFF, 15, 1'b0);
      // R2 and R10: start strobe and divider change while busy
      xfer(8'hC3, 8'h5A, 0, 1'b1);
      xfer(8'h96, 8'h69, 2, 1'b1);
      xfer(8'h1E, 8'hE1, 5, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule